// File: doc/BRIEF.md
# Single-Error-Correct Double-Error-Detect Word Protection Unit

This unit protects 16-bit memory words with 6 check bits. There are 5 Hamming bits and 1 overall parity bit, so each stored word is 22 bits wide. The write path is purely combinational. It takes the data about to be stored and produces the check bits that go beside it in memory. In diagnostic mode, software-supplied check bits replace the generated ones, so that chosen error patterns can be planted in memory.

The read path samples a stored word when a read is requested. It computes the syndrome and the overall parity. It then reports the result one clock later: clean, single error (with its location), or uncorrectable. A single error that needs a bit flipped in the returned word costs one more clock. During that extra clock a stall output is high and new read requests are refused. Correction can be switched off. Errors are then still reported, but the raw word is returned. The raw check bits read from memory are always returned next to the data, so that software can inspect them.

Codeword layout: positions 1 to 21 hold the Hamming code, and position 0 is the overall parity bit. Hamming bit i sits at position 2^i. Data bit j sits at the j-th position (counting from 1 upward) that is not a power of two. Data bit 0 is therefore at position 3, data bit 4 at position 9 and data bit 15 at position 21.

Top module: `ecc_word_unit`

## Requirements
- R1: `store_data` equals `wr_data`. Bit i of `store_chk[4:0]` is the XOR of the data bits whose position has bit i set. `store_chk[5]` is the XOR of all 16 data bits and the 5 Hamming bits. All of these are combinational from the inputs.
- R2: While `diag_en` is high, `store_chk` equals `diag_chk_in` and no longer follows the generator.
- R3: A read of an error-free word, requested in cycle n, gives `rd_ready` high in cycle n+1. In that cycle `rd_data` is the stored data and both error flags are low.
- R4: A single flipped bit at position p (1 to 21), read with correction enabled, gives the following. `rd_stall` is high in cycle n+1. `rd_ready` is high in cycle n+2 with the original data, `err_single` high and `err_pos` = p.
- R5: A flip of only the overall parity bit (position 0) gives `rd_ready` in cycle n+1. The data is unchanged, `err_single` is high and `err_pos` = 0.
- R6: Two flipped bits give `rd_ready` in cycle n+1 with `err_double` high, `err_single` low and the raw data. The two flags are never high together.
- R7: A word whose overall parity is wrong but whose syndrome is above 21 (no valid position) is reported as `err_double` with raw data.
- R8: With `corr_dis` high at the request, a single error is still flagged with its position. The raw data is returned in cycle n+1, with no stall.
- R9: A `rd_req` made while `rd_stall` is high is ignored: it produces no result.
- R10: `rd_chk` returns the 6 check bits exactly as read from memory, with any fault left in place.
- R11: During reset and after it, until a read is made, `rd_ready`, `rd_stall`, `err_single` and `err_double` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_data | input | 16 | Data about to be written |
| diag_en | input | 1 | Diagnostic mode: software check bits on write |
| diag_chk_in | input | 6 | Check bits used in diagnostic mode |
| store_data | output | 16 | Data to store |
| store_chk | output | 6 | Check bits to store |
| rd_req | input | 1 | Sample `mem_data`/`mem_chk` as a read this cycle |
| corr_dis | input | 1 | Correction off for this read |
| mem_data | input | 16 | Data read from memory |
| mem_chk | input | 6 | Check bits read from memory |
| rd_ready | output | 1 | Read result valid this cycle |
| rd_stall | output | 1 | Correction cycle under way; requests refused |
| rd_data | output | 16 | Returned data |
| rd_chk | output | 6 | Raw check bits of the returned word |
| err_single | output | 1 | Single error seen |
| err_double | output | 1 | Uncorrectable error seen |
| err_pos | output | 5 | Position of the single error (0 = overall parity bit) |

## Verification
The write-path outputs are checked one time step after the inputs are driven, with no clock in between. Read results are due on the first falling edge after the sampling edge for clean, uncorrectable, parity-bit-only and correction-disabled reads. Corrected reads show a stall on that first edge and their result on the second. The bench keeps a two-slot expectation pipeline per read. On every falling edge it compares the ready and stall outputs, and the payload when a result is due. It refuses a request in its model whenever it expects a stall, so that refused requests must produce nothing.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

   // Smallest number of Hamming bits that can address every position.
   function automatic int hamming_bits(int dw);
      int r;
      r = 0;
      for (int k = 15; k >= 1; k--) begin
         if ((1 << k) >= dw + k + 1) r = k;
      end
      return r;
   endfunction

   // Codeword position of data bit j: the j-th non-power-of-two index.
   function automatic int data_pos(int j);
      int cnt;
      int res;
      cnt = 0;
      res = 0;
      for (int p = 3; p < 256; p++) begin
         if ((p & (p - 1)) != 0) begin
            if (cnt == j) res = p;
            cnt++;
         end
      end
      return res;
   endfunction

   typedef enum logic [1:0] {
      RD_CLEAN  = 2'd0,
      RD_SINGLE = 2'd1,
      RD_DOUBLE = 2'd2
   } rd_class_e;

endpackage

// File: rtl/ecc_encoder.sv
module ecc_encoder #(
   parameter int DATA_W = 16,
   localparam int HAM_W = ecc_pkg::hamming_bits(DATA_W),
   localparam int CHK_W = HAM_W + 1
) (
   input  logic [DATA_W-1:0] data,
   output logic [CHK_W-1:0]  chk
);

   logic [HAM_W-1:0] ham;

   for (genvar i = 0; i < HAM_W; i++) begin : g_ham
      logic [DATA_W-1:0] taps;
      for (genvar j = 0; j < DATA_W; j++) begin : g_tap
         localparam int P = ecc_pkg::data_pos(j);
         if (((P >> i) & 1) != 0) begin : g_on
            assign taps[j] = data[j];
         end else begin : g_off
            assign taps[j] = 1'b0;
         end
      end
      assign ham[i] = ^taps;
   end

   assign chk = {(^data) ^ (^ham), ham};

endmodule

// File: rtl/ecc_check.sv
module ecc_check #(
   parameter int DATA_W = 16,
   localparam int HAM_W   = ecc_pkg::hamming_bits(DATA_W),
   localparam int CHK_W   = HAM_W + 1,
   localparam int MAX_POS = DATA_W + HAM_W
) (
   input  logic [DATA_W-1:0]  data,
   input  logic [CHK_W-1:0]   chk,
   output logic [HAM_W-1:0]   syn,
   output ecc_pkg::rd_class_e cls
);

   localparam logic [HAM_W-1:0] MAX_POS_V = HAM_W'(MAX_POS);

   logic [CHK_W-1:0] regen;
   logic             par_bad;

   ecc_encoder #(.DATA_W(DATA_W)) u_regen (
      .data (data),
      .chk  (regen)
   );

   assign syn     = regen[HAM_W-1:0] ^ chk[HAM_W-1:0];
   assign par_bad = (^data) ^ (^chk);

   always_comb begin
      if (!par_bad && syn == '0)      cls = ecc_pkg::RD_CLEAN;
      else if (par_bad && syn <= MAX_POS_V) cls = ecc_pkg::RD_SINGLE;
      else                            cls = ecc_pkg::RD_DOUBLE;
   end

endmodule

// File: rtl/ecc_fix.sv
module ecc_fix #(
   parameter int DATA_W = 16,
   localparam int HAM_W = ecc_pkg::hamming_bits(DATA_W)
) (
   input  logic [DATA_W-1:0] data,
   input  logic [HAM_W-1:0]  syn,
   output logic [DATA_W-1:0] fixed
);

   for (genvar j = 0; j < DATA_W; j++) begin : g_bit
      localparam int P = ecc_pkg::data_pos(j);
      assign fixed[j] = data[j] ^ (syn == HAM_W'(P));
   end

endmodule

// File: rtl/ecc_word_unit.sv
module ecc_word_unit #(
   parameter int DATA_W = 16,
   localparam int HAM_W = ecc_pkg::hamming_bits(DATA_W),
   localparam int CHK_W = HAM_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              diag_en,
   input  logic [CHK_W-1:0]  diag_chk_in,
   output logic [DATA_W-1:0] store_data,
   output logic [CHK_W-1:0]  store_chk,
   input  logic              rd_req,
   input  logic              corr_dis,
   input  logic [DATA_W-1:0] mem_data,
   input  logic [CHK_W-1:0]  mem_chk,
   output logic              rd_ready,
   output logic              rd_stall,
   output logic [DATA_W-1:0] rd_data,
   output logic [CHK_W-1:0]  rd_chk,
   output logic              err_single,
   output logic              err_double,
   output logic [HAM_W-1:0]  err_pos
);

   if (DATA_W < 4 || DATA_W > 200) begin : g_bad_width
      $error("ecc_word_unit: DATA_W must lie in 4..200");
   end
   if (HAM_W < 3) begin : g_bad_ham
      $error("ecc_word_unit: derived Hamming width too small");
   end

   // ---------------- write path ----------------
   logic [CHK_W-1:0] gen_chk;

   ecc_encoder #(.DATA_W(DATA_W)) u_enc (
      .data (wr_data),
      .chk  (gen_chk)
   );

   assign store_data = wr_data;
   assign store_chk  = diag_en ? diag_chk_in : gen_chk;

   // ---------------- read path: stage 1 ----------------
   logic [HAM_W-1:0]   syn;
   ecc_pkg::rd_class_e cls;

   ecc_check #(.DATA_W(DATA_W)) u_chk (
      .data (mem_data),
      .chk  (mem_chk),
      .syn  (syn),
      .cls  (cls)
   );

   logic              s1_v, s1_fix, s1_single, s1_double;
   logic [DATA_W-1:0] s1_data;
   logic [CHK_W-1:0]  s1_chk;
   logic [HAM_W-1:0]  s1_syn;
   logic              accept, fix_pend;

   assign fix_pend = s1_v & s1_fix;
   assign accept   = rd_req & ~fix_pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_v      <= 1'b0;
         s1_fix    <= 1'b0;
         s1_single <= 1'b0;
         s1_double <= 1'b0;
         s1_data   <= '0;
         s1_chk    <= '0;
         s1_syn    <= '0;
      end else begin
         s1_v <= accept;
         if (accept) begin
            s1_data   <= mem_data;
            s1_chk    <= mem_chk;
            s1_syn    <= syn;
            s1_single <= (cls == ecc_pkg::RD_SINGLE);
            s1_double <= (cls == ecc_pkg::RD_DOUBLE);
            s1_fix    <= (cls == ecc_pkg::RD_SINGLE) && (syn != '0) && !corr_dis;
         end
      end
   end

   // ---------------- read path: correction stage ----------------
   logic [DATA_W-1:0] fixed_data;
   logic [DATA_W-1:0] s2_data;
   logic              s2_v;

   ecc_fix #(.DATA_W(DATA_W)) u_fix (
      .data  (s1_data),
      .syn   (s1_syn),
      .fixed (fixed_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s2_v    <= 1'b0;
         s2_data <= '0;
      end else begin
         s2_v <= fix_pend;
         if (fix_pend) s2_data <= fixed_data;
      end
   end

   // Stage-1 registers hold during the correction cycle (no accept),
   // so flags, check bits and position serve both result paths.
   assign rd_ready   = (s1_v & ~s1_fix) | s2_v;
   assign rd_stall   = fix_pend;
   assign rd_data    = s2_v ? s2_data : s1_data;
   assign rd_chk     = s1_chk;
   assign err_single = rd_ready & s1_single;
   assign err_double = rd_ready & s1_double;
   assign err_pos    = (rd_ready & s1_single) ? s1_syn : '0;

   // ---------------- assertions ----------------
   AST_CLEAN_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (rd_ready || rd_stall)); // R3

   AST_STALL_THEN_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stall |=> (rd_ready && !rd_stall)); // R4

   AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({err_single, err_double})); // R6

   AST_DISABLED_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && corr_dis) |=> !rd_stall); // R8

   AST_REFUSED_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stall && rd_req) |=> !rd_stall); // R9

endmodule

// File: tb/tb_ecc_word_unit.sv
`timescale 1ns/1ps
module tb_ecc_word_unit;

   typedef struct packed {
      logic        stall;
      logic        ready;
      logic [15:0] data;
      logic [5:0]  chk;
      logic        single;
      logic        dbl;
      logic [4:0]  pos;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] wr_data = '0;
   logic        diag_en = 1'b0;
   logic [5:0]  diag_chk_in = '0;
   logic [15:0] store_data;
   logic [5:0]  store_chk;
   logic        rd_req = 1'b0;
   logic        corr_dis = 1'b0;
   logic [15:0] mem_data = '0;
   logic [5:0]  mem_chk = '0;
   logic        rd_ready, rd_stall;
   logic [15:0] rd_data;
   logic [5:0]  rd_chk;
   logic        err_single, err_double;
   logic [4:0]  err_pos;

   int n_vec = 0;
   int n_bad = 0;

   exp_t  slot_a = '0, slot_b = '0;
   string tag_a = "", tag_b = "";

   always #10 clk = ~clk;

   ecc_word_unit dut (
      .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .diag_en(diag_en),
      .diag_chk_in(diag_chk_in), .store_data(store_data), .store_chk(store_chk),
      .rd_req(rd_req), .corr_dis(corr_dis), .mem_data(mem_data), .mem_chk(mem_chk),
      .rd_ready(rd_ready), .rd_stall(rd_stall), .rd_data(rd_data), .rd_chk(rd_chk),
      .err_single(err_single), .err_double(err_double), .err_pos(err_pos)
   );

   // ---- behavioural codeword model: bit p of w is codeword position p ----
   function automatic logic [21:0] pack(logic [15:0] d, logic [5:0] c);
      logic [21:0] w;
      int k = 0;
      int h = 0;
      w[0] = c[5];
      for (int p = 1; p <= 21; p++) begin
         if ((p & (p - 1)) == 0) begin w[p] = c[h]; h++; end
         else begin w[p] = d[k]; k++; end
      end
      return w;
   endfunction

   function automatic logic [21:0] unpack(logic [21:0] w);
      logic [15:0] d;
      logic [5:0]  c;
      int k = 0;
      int h = 0;
      c[5] = w[0];
      for (int p = 1; p <= 21; p++) begin
         if ((p & (p - 1)) == 0) begin c[h] = w[p]; h++; end
         else begin d[k] = w[p]; k++; end
      end
      return {c, d};
   endfunction

   function automatic logic [5:0] encode(logic [15:0] d);
      logic [21:0] w;
      logic [5:0]  c = '0;
      w = pack(d, '0);
      for (int i = 0; i < 5; i++) begin
         logic b = 1'b0;
         for (int p = 1; p <= 21; p++) if (((p >> i) & 1) != 0) b ^= w[p];
         c[i] = b;
      end
      w = pack(d, c);
      c[5] = ^w[21:1];
      return c;
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   // One clock: check at this falling edge, drive, advance the model.
   task automatic cycle(logic req, logic [15:0] d, logic [5:0] c, logic dis,
                        exp_t res, logic fix, string tag);
      exp_t  now;
      string t;
      now = slot_a;
      t   = (now.stall || now.ready) ? tag_a : tag;
      check({t, " stall"}, 32'(rd_stall), 32'(now.stall));
      check({t, " ready"}, 32'(rd_ready), 32'(now.ready));
      if (now.ready) begin
         check({t, " data"}, 32'(rd_data), 32'(now.data));
         check({"R10 ", t, " chk"}, 32'(rd_chk), 32'(now.chk));
         check({t, " single"}, 32'(err_single), 32'(now.single));
         check({t, " double"}, 32'(err_double), 32'(now.dbl));
         if (now.single) check({t, " pos"}, 32'(err_pos), 32'(now.pos));
      end
      rd_req = req; mem_data = d; mem_chk = c; corr_dis = dis;
      slot_a = slot_b; tag_a = tag_b; slot_b = '0; tag_b = "";
      if (req && !now.stall) begin
         if (fix) begin
            slot_a = '0; slot_a.stall = 1'b1; tag_a = tag;
            slot_b = res; tag_b = tag;
         end else begin
            slot_a = res; tag_a = tag;
         end
      end
      @(negedge clk);
   endtask

   task automatic idle(string tag);
      cycle(1'b0, '0, '0, 1'b0, '0, 1'b0, tag);
   endtask

   // Read of word d with up to three flipped positions (-1 = none).
   task automatic do_read(logic [15:0] d, int f1, int f2, int f3, logic dis, string tag);
      logic [21:0] w, u;
      int    n = 0;
      exp_t  r = '0;
      logic  fix;
      w = pack(d, encode(d));
      if (f1 >= 0) begin w[f1] = ~w[f1]; n++; end
      if (f2 >= 0) begin w[f2] = ~w[f2]; n++; end
      if (f3 >= 0) begin w[f3] = ~w[f3]; n++; end
      u = unpack(w);
      r.ready  = 1'b1;
      r.chk    = u[21:16];
      r.single = (n == 1);
      r.dbl    = (n >= 2);
      r.pos    = (n == 1) ? 5'(f1) : 5'd0;
      fix      = (n == 1) && (f1 != 0) && !dis;
      r.data   = (n == 1 && !dis) ? d : u[15:0];
      cycle(1'b1, u[15:0], u[21:16], dis, r, fix, tag);
   endtask

   task automatic wr_check(logic [15:0] d, logic dg, logic [5:0] dc, string tag);
      wr_data = d; diag_en = dg; diag_chk_in = dc;
      #1;
      check({tag, " store_data"}, 32'(store_data), 32'(d));
      check({tag, " store_chk"}, 32'(store_chk), 32'(dg ? dc : encode(d)));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      // R11: reset state
      check("R11 ready", 32'(rd_ready), 32'd0);
      check("R11 stall", 32'(rd_stall), 32'd0);
      check("R11 flags", 32'({err_single, err_double}), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      idle("R11");

      // R1 and R2: write path
      wr_check(16'h0000, 1'b0, '0, "R1");
      wr_check(16'hFFFF, 1'b0, '0, "R1");
      wr_check(16'hA5A5, 1'b0, '0, "R1");
      wr_check(16'h8001, 1'b0, '0, "R1");
      wr_check(16'h1234, 1'b1, 6'h2A, "R2");
      wr_check(16'h1234, 1'b1, 6'h15, "R2");
      diag_en = 1'b0;

      // R3: clean reads, back to back
      do_read(16'h0000, -1, -1, -1, 1'b0, "R3");
      do_read(16'hFFFF, -1, -1, -1, 1'b0, "R3");
      do_read(16'h5A3C, -1, -1, -1, 1'b0, "R3");
      do_read(16'h0001, -1, -1, -1, 1'b0, "R3");
      idle("R3");

      // R4: every correctable position, with a stall cycle each
      for (int p = 1; p <= 21; p++) begin
         do_read(16'hC3A5, p, -1, -1, 1'b0, "R4");
         idle("R4");
      end
      idle("R4");

      // R5: overall parity bit only
      do_read(16'h7E81, 0, -1, -1, 1'b0, "R5");
      idle("R5");

      // R6: double errors
      do_read(16'h1357, 1, 2, -1, 1'b0, "R6");
      do_read(16'h1357, 3, 21, -1, 1'b0, "R6");
      do_read(16'h2468, 0, 7, -1, 1'b0, "R6");
      do_read(16'hFFFF, 5, 6, -1, 1'b0, "R6");
      idle("R6");

      // R7: odd parity but syndrome beyond 21
      do_read(16'h0F0F, 16, 8, 1, 1'b0, "R7");
      do_read(16'hF0F0, 16, 4, 2, 1'b0, "R7");
      idle("R7");

      // R8: correction disabled
      do_read(16'hBEEF, 3, -1, -1, 1'b1, "R8");
      do_read(16'hBEEF, 21, -1, -1, 1'b1, "R8");
      do_read(16'hCAFE, 2, -1, -1, 1'b1, "R8");
      do_read(16'hCAFE, 4, 9, -1, 1'b1, "R8");
      idle("R8");

      // R9: request during the correction cycle is refused
      do_read(16'h4242, 9, -1, -1, 1'b0, "R9");
      do_read(16'h9999, -1, -1, -1, 1'b0, "R9");
      idle("R9");
      idle("R9");
      idle("R9");

      summary();
   end

endmodule